// File: doc/BRIEF.md
# Two-round SHA-512 compression core

This core runs the SHA-512 compression function over one 1024-bit message block. It starts from a 512-bit chaining value and returns the next 512-bit hash state. The caller either supplies the chaining value or lets the core use the standard SHA-512 starting state. The caller also supplies the expanded message schedule, two 64-bit words per accepted cycle. Padding, parsing a message into blocks and expanding the schedule all happen outside the core.

Each update of the working registers covers two consecutive SHA-512 rounds, so the 80 rounds take 40 register updates. In each iteration only a, b, e and f need new arithmetic. The other four words are copies of values from the previous iteration. Each schedule pair is added to its two round constants one clock before the pair is consumed. This takes the constant addition out of the double-round path. The 80 round constants are computed at elaboration from the first 80 primes, and the starting state from the first eight primes. Neither is stored as a literal table.

Top module: `sha512_dround`

## Requirements
- R1: While reset is held and after it is released, done and busy are 0 and digest is all zeros.
- R2: When chain_ext is 0 at the accepted start, the block is compressed from the standard SHA-512 initial hash state. For the padded single block of "abc", the digest equals the published SHA-512 answer for "abc".
- R3: When chain_ext is 1 at the accepted start, chain_in is the starting state. Word 0 (variable a) sits in bits 511:448 and word 7 (h) in bits 63:0. Each digest word is the modulo 2^64 sum of the chain word and the final working variable in the same position, packed in the same order.
- R4: A start seen while idle sets busy on the next cycle. From then on, every cycle with w_valid high and busy high accepts one pair. Pair j carries schedule word 2j on w_even and word 2j+1 on w_odd. Cycles with w_valid low stall the computation without corrupting it.
- R5: done is high for exactly one clock per block. busy falls on the same edge at which done rises.
- R6: If w_valid is held high from the cycle after the start edge, done rises on the 41st rising edge after the edge that captured start.
- R7: w_valid while idle, and pairs offered after the 40th accepted pair, have no effect on the digest.
- R8: A start asserted while busy is ignored: chain_in and chain_ext are not resampled and the running block finishes with its original result.
- R9: digest holds its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; sampled only while idle |
| chain_ext | input | 1 | 1: start from chain_in, 0: start from the standard initial state |
| chain_in | input | 512 | Caller chaining value, word 0 in the top 64 bits |
| w_valid | input | 1 | A schedule pair is present on w_even/w_odd |
| w_even | input | 64 | Schedule word 2j of pair j |
| w_odd | input | 64 | Schedule word 2j+1 of pair j |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse when digest is updated |
| digest | output | 512 | Resulting hash state, word 0 in the top 64 bits |

## Verification
The bound assertions check four things on every cycle. done never lasts two cycles. digest changes only when done is raised. busy rises only after a start. A start raised while busy leaves the block running until its done pulse. Only the bench scenarios can show that the arithmetic is right. They check a published known answer, a software reference over several random blocks and chaining values, and stall patterns of several densities. They also check the 41-edge latency and that stray starts and surplus schedule pairs do not disturb the result.

// File: rtl/sha512_dround.sv
module sha512_dround (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         chain_ext,
  input  logic [511:0] chain_in,
  input  logic         w_valid,
  input  logic [63:0]  w_even,
  input  logic [63:0]  w_odd,
  output logic         busy,
  output logic         done,
  output logic [511:0] digest
);
  localparam int NR = 80;
  localparam int NI = NR / 2;
  localparam int CW = $clog2(NI + 1);
  localparam logic [CW-1:0] ITER_END = CW'(NI);
  localparam logic [CW-1:0] ITER_LAST = CW'(NI - 1);

  function automatic int nth_prime(int n);
    int c = 1;
    int seen = -1;
    while (seen < n) begin
      bit ok = 1'b1;
      c++;
      for (int d = 2; d * d <= c; d++)
        if (c % d == 0) ok = 1'b0;
      if (ok) seen++;
    end
    return c;
  endfunction

  function automatic logic [63:0] root_frac(int p, int deg);
    logic [255:0] n, r, t, pw;
    n = (deg == 3) ? (256'(p) << 192) : (256'(p) << 128);
    r = '0;
    for (int b = 67; b >= 0; b--) begin
      t  = r | (256'd1 << b);
      pw = (deg == 3) ? t * t * t : t * t;
      if (pw <= n) r = t;
    end
    return r[63:0];
  endfunction

  function automatic logic [64*NR-1:0] make_k();
    logic [64*NR-1:0] v;
    for (int i = 0; i < NR; i++) v[i*64 +: 64] = root_frac(nth_prime(i), 3);
    return v;
  endfunction

  function automatic logic [511:0] make_iv();
    logic [511:0] v;
    for (int i = 0; i < 8; i++) v[(7-i)*64 +: 64] = root_frac(nth_prime(i), 2);
    return v;
  endfunction

  localparam logic [64*NR-1:0] KTAB = make_k();
  localparam logic [511:0] IV_STD = make_iv();

  function automatic logic [63:0] rotr(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [511:0] one_round(logic [511:0] s, logic [63:0] wk);
    logic [63:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = s;
    t1 = h + (rotr(e, 14) ^ rotr(e, 18) ^ rotr(e, 41)) + ((e & f) ^ (~e & g)) + wk;
    t2 = (rotr(a, 28) ^ rotr(a, 34) ^ rotr(a, 39)) + ((a & b) ^ (a & c) ^ (b & c));
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  logic [CW-1:0]  cnt_in, cnt_rd;
  logic           wk_v;
  logic [63:0]    wk0, wk1;
  logic [511:0]   st, chain_q, nxt, sum, init;
  logic [12:0]    kidx;

  assign kidx = {cnt_in, 7'd0};
  assign init = chain_ext ? chain_in : IV_STD;
  assign nxt  = one_round(one_round(st, wk0), wk1);

  for (genvar i = 0; i < 8; i++) begin : g_fold
    assign sum[i*64 +: 64] = chain_q[i*64 +: 64] + nxt[i*64 +: 64];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt_in  <= '0;
      cnt_rd  <= '0;
      wk_v    <= 1'b0;
      wk0     <= '0;
      wk1     <= '0;
      st      <= '0;
      chain_q <= '0;
      digest  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        wk_v <= 1'b0;
        if (start) begin
          busy    <= 1'b1;
          st      <= init;
          chain_q <= init;
          cnt_in  <= '0;
          cnt_rd  <= '0;
        end
      end else begin
        if (w_valid && cnt_in != ITER_END) begin
          wk0    <= w_even + KTAB[kidx +: 64];
          wk1    <= w_odd + KTAB[kidx + 13'd64 +: 64];
          wk_v   <= 1'b1;
          cnt_in <= cnt_in + 1'b1;
        end else begin
          wk_v <= 1'b0;
        end
        if (wk_v) begin
          st     <= nxt;
          cnt_rd <= cnt_rd + 1'b1;
          if (cnt_rd == ITER_LAST) begin
            digest <= sum;
            done   <= 1'b1;
            busy   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sha512_dround_chk.sv
module sha512_dround_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [511:0] digest
);
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_digest_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest));

  a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  a_r4_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind sha512_dround sha512_dround_chk u_chk (.*);

// File: tb/sim_sha512_dround.sv
module sim_sha512_dround;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, chain_ext = 1'b0, w_valid = 1'b0;
  logic [511:0] chain_in = '0;
  logic [63:0] w_even = '0, w_odd = '0;
  logic busy, done;
  logic [511:0] digest;

  sha512_dround u0 (.clk(clk), .rst_n(rst_n), .start(start), .chain_ext(chain_ext),
    .chain_in(chain_in), .w_valid(w_valid), .w_even(w_even), .w_odd(w_odd),
    .busy(busy), .done(done), .digest(digest));

  always #5ns clk = ~clk;

  int total = 0, bad = 0, cyc = 0, done_seen = 0, done_cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (done) begin done_seen++; done_cyc = cyc; end

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    finished = 1'b1;
    total++; bad++;
    $display("FAIL watchdog act=%0d exp<=150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [63:0] KB[80];
  logic [63:0] IVB[8];
  logic [63:0] blk[16];
  logic [63:0] Wm[80];

  function automatic logic [63:0] froot(int p, int deg);
    logic [255:0] lo, hi, mid, n, pw;
    n = (deg == 3) ? (256'(p) << 192) : (256'(p) << 128);
    lo = '0; hi = 256'd1 << 68;
    for (int it = 0; it < 70; it++) begin
      mid = (lo + hi) >> 1;
      pw = (deg == 3) ? mid * mid * mid : mid * mid;
      if (pw <= n) lo = mid; else hi = mid;
    end
    return lo[63:0];
  endfunction

  function automatic logic [63:0] ror(logic [63:0] x, int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  task automatic build_consts();
    int found = 0;
    for (int c = 2; found < 80; c++) begin
      bit pr = 1'b1;
      for (int d = 2; d < c; d++) if (c % d == 0) pr = 1'b0;
      if (pr) begin
        KB[found] = froot(c, 3);
        if (found < 8) IVB[found] = froot(c, 2);
        found++;
      end
    end
  endtask

  task automatic expand();
    for (int t = 0; t < 80; t++) begin
      if (t < 16) Wm[t] = blk[t];
      else Wm[t] = (ror(Wm[t-2], 19) ^ ror(Wm[t-2], 61) ^ (Wm[t-2] >> 6)) + Wm[t-7]
                 + (ror(Wm[t-15], 1) ^ ror(Wm[t-15], 8) ^ (Wm[t-15] >> 7)) + Wm[t-16];
    end
  endtask

  function automatic logic [511:0] ref_hash(logic [511:0] cv);
    logic [63:0] v[8];
    logic [63:0] t1, t2;
    logic [511:0] r;
    for (int i = 0; i < 8; i++) v[i] = cv[(7-i)*64 +: 64];
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + (ror(v[4], 14) ^ ror(v[4], 18) ^ ror(v[4], 41))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KB[t] + Wm[t];
      t2 = (ror(v[0], 28) ^ ror(v[0], 34) ^ ror(v[0], 39))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[(7-i)*64 +: 64] = cv[(7-i)*64 +: 64] + v[i];
    return r;
  endfunction

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [511:0] run_dg;
  int run_lat, run_dcnt;

  task automatic run(bit ext, logic [511:0] cv, int gap, bit poke);
    int s_cyc, waited;
    @(negedge clk);
    start = 1'b1; chain_ext = ext; chain_in = cv; s_cyc = cyc; done_seen = 0;
    @(negedge clk);
    start = 1'b0; chain_ext = ~ext; chain_in = ~cv;
    for (int j = 0; j < 40; j++) begin
      if (gap > 0 && (j % gap) == 1) begin
        w_valid = 1'b0; w_even = ~Wm[2*j]; w_odd = 64'hdead;
        @(negedge clk);
      end
      w_valid = 1'b1; w_even = Wm[2*j]; w_odd = Wm[2*j+1];
      if (poke && j == 10) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int x = 0; x < 3; x++) begin
      w_valid = 1'b1; w_even = 64'h1234 + 64'(x); w_odd = 64'hffff_0000 ^ 64'(x);
      @(negedge clk);
    end
    w_valid = 1'b0;
    waited = 0;
    while (done_seen == 0 && waited < 200) begin @(negedge clk); waited++; end
    repeat (4) @(negedge clk);
    run_dg = digest; run_lat = done_cyc - s_cyc; run_dcnt = done_seen;
  endtask

  localparam logic [511:0] ABC_DIGEST = {
    64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2, 64'h0a9eeee64b55d39a,
    64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd, 64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};

  initial begin
    logic [511:0] ivp, cv, held;
    build_consts();
    for (int i = 0; i < 8; i++) ivp[(7-i)*64 +: 64] = IVB[i];

    repeat (3) @(negedge clk);
    chk("R1 reset done/busy", {510'd0, done, busy}, '0);
    chk("R1 reset digest", digest, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {digest[510:0], done ^ busy}, '0);

    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 64'h6162638000000000;
    blk[15] = 64'h18;
    expand();

    run(1'b0, '0, 0, 1'b0);
    chk("R2 abc default state", run_dg, ABC_DIGEST);
    chk("R6 latency edges", 512'(run_lat), 512'd42);
    chk("R5 single done pulse", 512'(run_dcnt), 512'd1);
    chk("R5 busy low after done", 512'(busy), 512'd0);

    held = digest;
    for (int x = 0; x < 6; x++) begin
      w_valid = 1'b1; w_even = 64'(x) * 64'h0101; w_odd = ~64'(x);
      @(negedge clk);
    end
    w_valid = 1'b0;
    chk("R9 digest held while idle", digest, held);
    chk("R7 idle valid keeps idle", 512'(busy), 512'd0);

    run(1'b1, ivp, 0, 1'b0);
    chk("R3 abc with supplied chain", run_dg, ABC_DIGEST);

    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 16; i++) blk[i] = {$urandom, $urandom};
      for (int i = 0; i < 16; i++) cv[i*32 +: 32] = $urandom;
      expand();
      run(1'b1, cv, k, k[0]);
      chk($sformatf("R3 R4 R7 R8 random block %0d", k), run_dg, ref_hash(cv));
      chk($sformatf("R5 done count block %0d", k), 512'(run_dcnt), 512'd1);
    end

    for (int i = 0; i < 16; i++) blk[i] = {$urandom, $urandom};
    expand();
    run(1'b0, {16{32'h5a5a_a5a5}}, 3, 1'b1);
    chk("R2 R4 default state stalled", run_dg, ref_hash(ivp));
    held = digest;
    repeat (5) @(negedge clk);
    chk("R9 digest held after run", digest, held);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule